// File: doc/BRIEF.md
# Byte-Gathering Packing DMA Channel

This block is a single-channel transfer engine that sits behind an SPI buffer sequencer. Each receive buffer word in the source memory is 32 bits wide. Its upper half holds status and control bits. Its lower half holds received data, and with 8-bit characters only the lowest byte of it is valid. When the sequencer reports that the buffer whose index matches the configured trigger index has completed, the channel runs one frame. A frame is four byte reads from the source memory at a programmable byte stride, packed into one 32-bit word. That word is written into a circular destination region.

The source side is a plain synchronous memory port. The read strobe and byte address go out in one cycle and the whole 32-bit word comes back on the next cycle, with no stall. The channel picks the byte lane named by the low two address bits. The destination side is a valid/ready stream of address and data. Once `dst_wr_valid` is high, it stays high and address and data stay unchanged until a cycle in which `dst_wr_ready` is also high; that cycle completes the write. The sink may hold `dst_wr_ready` low for any number of cycles. The channel does not need `dst_wr_ready` to be high before it raises valid.

The destination pointer steps by a programmable stride after every completed write. It goes back to the base address after a programmable number of words and pulses a wrap flag when it does. A destination base or stride that is not on a 4-byte boundary blocks the frame and sets a sticky error flag. Configuration inputs must be held steady while `busy` is high.

Top module: `byte_pack_dma`

## Requirements
- R1: A frame is requested only in a cycle where `seq_done_valid` is 1 and `seq_done_idx` equals `cfg_buf_id`; a completion with any other index causes no read and no write.
- R2: A frame issues exactly four byte reads, at `cfg_src_base + k*cfg_src_stride` for k = 0,1,2,3. Any byte address is allowed, and the byte taken is lane addr[1:0] of the returned word, lane n being bits [8n+7:8n].
- R3: The packed word is big-endian: the byte of read k=0 lands in bits [31:24], k=1 in [23:16], k=2 in [15:8], k=3 in [7:0].
- R4: The n-th write since reset or since the last wrap goes to `cfg_dst_base + n*cfg_dst_stride`.
- R5: After `cfg_ring_words` completed writes (a value of 0 counts as 1), the pointer returns to `cfg_dst_base`. `wrap_pulse` is 1 for exactly the one cycle after the handshake of that last write, and 0 otherwise.
- R6: If `cfg_dst_base[1:0]` or `cfg_dst_stride[1:0]` is nonzero when a frame would start, no read and no write happen for it. `align_err` then becomes 1 and stays 1 until reset.
- R7: A matching request that arrives while a frame is in progress is held as pending and starts a new frame as soon as the current write completes; several such requests merge into one pending frame.
- R8: While `dst_wr_valid` is 1 and `dst_wr_ready` is 0, the next cycle keeps `dst_wr_valid` at 1 with the same address and data.
- R9: After reset, `dst_wr_valid`, `src_rd_en`, `busy`, `wrap_pulse` and `align_err` are 0.
- R10: A matching request in the same cycle as a write handshake, including a wrapping one, is not lost and starts the next frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_buf_id | input | 6 | Buffer index whose completion triggers a frame |
| cfg_src_base | input | 16 | Byte address of the first byte read |
| cfg_src_stride | input | 8 | Byte step between reads |
| cfg_dst_base | input | 16 | Base byte address of the circular region (4-byte aligned) |
| cfg_dst_stride | input | 8 | Byte step between written words (4-byte aligned) |
| cfg_ring_words | input | 10 | Number of words in the circular region |
| seq_done_valid | input | 1 | Sequencer reports a completed buffer |
| seq_done_idx | input | 6 | Index of the completed buffer |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | 16 | Source byte address |
| src_rd_data | input | 32 | Source word, one cycle after the strobe |
| dst_wr_valid | output | 1 | Packed word offered |
| dst_wr_ready | input | 1 | Sink accepts the word |
| dst_wr_addr | output | 16 | Destination byte address |
| dst_wr_data | output | 32 | Packed word |
| busy | output | 1 | A frame is gathering or waiting to be written |
| wrap_pulse | output | 1 | One-cycle flag after the write that wraps the region |
| align_err | output | 1 | Sticky flag for a blocked misaligned frame |

## Verification
Two functions can fall in the same cycle: the write handshake that ends a frame, possibly the one that wraps the ring, and a new matching request that the engine must take up. The bench holds the sink stalled until the packed word is offered. It then raises `dst_wr_ready` and a matching `seq_done_valid` on the same clock, with the ring sized so that this write wraps. The scoreboard expects two writes: the first at the last ring slot with a wrap pulse after it, and the second back at the base address with the data of a fresh frame.

// File: rtl/byte_pack_pkg.sv
package byte_pack_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_PUSH   = 2'd2
  } bp_state_e;

endpackage

// File: rtl/bp_req_ctrl.sv
module bp_req_ctrl #(
  parameter int IDW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           done_valid,
  input  logic [IDW-1:0] done_idx,
  input  logic [IDW-1:0] trig_idx,
  input  logic           slot_free,
  output logic           want
);

  logic hit;
  logic pend_q;

  assign hit  = done_valid && (done_idx == trig_idx);
  assign want = hit || pend_q;

  // A request seen while the engine cannot take it is remembered once.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (slot_free) begin
      pend_q <= 1'b0;
    end else if (hit) begin
      pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/bp_gather.sv
module bp_gather #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] stride,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          word_done,
  output logic [DW-1:0] word
);

  localparam int ELEMS = DW / 8;
  localparam int LW    = $clog2(ELEMS);
  localparam int CNTW  = $clog2(ELEMS + 1);

  logic            active_q;
  logic [AW-1:0]   ptr_q;
  logic [CNTW-1:0] iss_q;
  logic [CNTW-1:0] rcv_q;
  logic            rv_q;
  logic [LW-1:0]   lane_q;
  logic [DW-1:0]   acc_q;
  logic            done_q;
  logic [7:0]      sel_byte;

  assign rd_en     = active_q && (iss_q != CNTW'(ELEMS));
  assign rd_addr   = ptr_q;
  assign sel_byte  = rd_data[{lane_q, 3'b000} +: 8];
  assign word_done = done_q;
  assign word      = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      iss_q    <= '0;
      rcv_q    <= '0;
      rv_q     <= 1'b0;
      lane_q   <= '0;
      acc_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      rv_q   <= rd_en;
      lane_q <= rd_addr[LW-1:0];
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        ptr_q    <= base;
        iss_q    <= '0;
        rcv_q    <= '0;
        acc_q    <= '0;
      end else begin
        if (rd_en) begin
          ptr_q <= ptr_q + AW'(stride);
          iss_q <= iss_q + 1'b1;
        end
        if (rv_q) begin
          // Earlier bytes shift upward: first read ends in the top lane.
          acc_q <= {acc_q[DW-9:0], sel_byte};
          rcv_q <= rcv_q + 1'b1;
          if (rcv_q == CNTW'(ELEMS - 1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  // R2: never more reads issued than a frame holds
  assert_read_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (iss_q < CNTW'(ELEMS)));

endmodule

// File: rtl/bp_dst_ring.sv
module bp_dst_ring #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int SW = 8,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] stride,
  input  logic [CW-1:0] ring_words,
  output logic [AW-1:0] addr,
  output logic          misaligned,
  output logic          wrap_pulse
);

  localparam int AL = $clog2(DW / 8);

  logic [AW-1:0] off_q;
  logic [CW-1:0] cnt_q;
  logic          last;
  logic          wrap_q;

  assign addr       = base + off_q;
  assign misaligned = (base[AL-1:0] != '0) || (stride[AL-1:0] != '0);
  assign last       = (ring_words == '0) ||
                      (({1'b0, cnt_q} + 1'b1) >= {1'b0, ring_words});
  assign wrap_pulse = wrap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= fire && last;
      if (fire) begin
        if (last) begin
          off_q <= '0;
          cnt_q <= '0;
        end else begin
          off_q <= off_q + AW'(stride);
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5: a wrap flag only ever follows a completed write
  assert_wrap_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> $past(fire));

  // R5: after a wrap the pointer sits at the base
  assert_wrap_to_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (off_q == '0));

endmodule

// File: rtl/byte_pack_dma.sv
module byte_pack_dma
  import byte_pack_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 16,
  parameter int SW  = 8,
  parameter int IDW = 6,
  parameter int CW  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IDW-1:0] cfg_buf_id,
  input  logic [AW-1:0]  cfg_src_base,
  input  logic [SW-1:0]  cfg_src_stride,
  input  logic [AW-1:0]  cfg_dst_base,
  input  logic [SW-1:0]  cfg_dst_stride,
  input  logic [CW-1:0]  cfg_ring_words,
  input  logic           seq_done_valid,
  input  logic [IDW-1:0] seq_done_idx,
  output logic           src_rd_en,
  output logic [AW-1:0]  src_rd_addr,
  input  logic [DW-1:0]  src_rd_data,
  output logic           dst_wr_valid,
  input  logic           dst_wr_ready,
  output logic [AW-1:0]  dst_wr_addr,
  output logic [DW-1:0]  dst_wr_data,
  output logic           busy,
  output logic           wrap_pulse,
  output logic           align_err
);

  localparam int AL = $clog2(DW / 8);

  bp_state_e state_q;
  logic      fire;
  logic      slot_free;
  logic      want;
  logic      mis;
  logic      launch;
  logic      reject;
  logic      word_done;
  logic      err_q;

  assign fire      = (state_q == ST_PUSH) && dst_wr_ready;
  assign slot_free = (state_q == ST_IDLE) || fire;
  assign launch    = slot_free && want && !mis;
  assign reject    = slot_free && want && mis;

  assign dst_wr_valid = (state_q == ST_PUSH);
  assign busy         = (state_q != ST_IDLE);
  assign align_err    = err_q;

  bp_req_ctrl #(.IDW(IDW)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_valid (seq_done_valid),
    .done_idx   (seq_done_idx),
    .trig_idx   (cfg_buf_id),
    .slot_free  (slot_free),
    .want       (want)
  );

  bp_gather #(.DW(DW), .AW(AW), .SW(SW)) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (launch),
    .base      (cfg_src_base),
    .stride    (cfg_src_stride),
    .rd_en     (src_rd_en),
    .rd_addr   (src_rd_addr),
    .rd_data   (src_rd_data),
    .word_done (word_done),
    .word      (dst_wr_data)
  );

  bp_dst_ring #(.DW(DW), .AW(AW), .SW(SW), .CW(CW)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .base       (cfg_dst_base),
    .stride     (cfg_dst_stride),
    .ring_words (cfg_ring_words),
    .addr       (dst_wr_addr),
    .misaligned (mis),
    .wrap_pulse (wrap_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      if (reject) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE:   if (launch) state_q <= ST_GATHER;
        ST_GATHER: if (word_done) state_q <= ST_PUSH;
        ST_PUSH:   if (fire) state_q <= launch ? ST_GATHER : ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: an offered word waits unchanged for the sink
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_valid && !dst_wr_ready) |=>
      (dst_wr_valid && $stable(dst_wr_data) && $stable(dst_wr_addr)));

  // R6: every offered write lands on a word boundary
  assert_wr_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_valid |-> (dst_wr_addr[AL-1:0] == '0));

  // R6: the error flag is sticky
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);

  // R2: reads and the outgoing write never overlap
  assert_no_read_in_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_valid |-> !src_rd_en);

endmodule

// File: tb/test_byte_pack_dma.sv
module test_byte_pack_dma;

  localparam int DW = 32, AW = 16, SW = 8, IDW = 6, CW = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [IDW-1:0] cfg_buf_id = 6'd3;
  logic [AW-1:0]  cfg_src_base = '0;
  logic [SW-1:0]  cfg_src_stride = 8'd4;
  logic [AW-1:0]  cfg_dst_base = 16'h0100;
  logic [SW-1:0]  cfg_dst_stride = 8'd4;
  logic [CW-1:0]  cfg_ring_words = 10'd3;
  logic           seq_done_valid = 1'b0;
  logic [IDW-1:0] seq_done_idx = '0;
  logic           src_rd_en;
  logic [AW-1:0]  src_rd_addr;
  logic [DW-1:0]  src_rd_data = '0;
  logic           dst_wr_valid;
  logic           dst_wr_ready = 1'b1;
  logic [AW-1:0]  dst_wr_addr;
  logic [DW-1:0]  dst_wr_data;
  logic           busy;
  logic           wrap_pulse;
  logic           align_err;

  always #10 clk = ~clk;

  byte_pack_dma i_byte_pack_dma (.*);

  int errors = 0;
  int checks = 0;
  bit rand_ready = 1'b0;
  bit finished = 1'b0;

  logic [AW+DW:0] exp_q[$];
  int model_off = 0;
  int model_cnt = 0;

  function automatic logic [31:0] src_word(input logic [AW-1:0] wi);
    logic [7:0] i;
    i = wi[7:0];
    return {i ^ 8'hA5, 8'hC0 + i, i * 8'd7 + 8'd3, 8'h11 + i};
  endfunction

  // synchronous source memory, one-cycle latency
  always @(posedge clk) if (src_rd_en) src_rd_data <= src_word(src_rd_addr >> 2);

  always @(negedge clk) if (rand_ready) dst_wr_ready = 1'($urandom_range(0, 1));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // R2 R3: expected packed word from the requirement formulas
  function automatic logic [31:0] exp_pack();
    logic [31:0] acc = '0;
    for (int k = 0; k < 4; k++) begin
      logic [AW-1:0] a;
      logic [31:0] w;
      a = cfg_src_base + AW'(k) * AW'(cfg_src_stride);
      w = src_word(a >> 2);
      acc = {acc[23:0], w[8*a[1:0] +: 8]};
    end
    return acc;
  endfunction

  // R4 R5: push one expected write, advancing the ring model
  task automatic expect_frame();
    logic [AW-1:0] a;
    bit wr;
    int rw;
    rw = (cfg_ring_words == 0) ? 1 : int'(cfg_ring_words);
    a = cfg_dst_base + AW'(model_off);
    wr = (model_cnt + 1 >= rw);
    exp_q.push_back({wr, a, exp_pack()});
    if (wr) begin model_off = 0; model_cnt = 0; end
    else begin model_off += int'(cfg_dst_stride); model_cnt++; end
  endtask

  task automatic send_req(input logic [IDW-1:0] idx);
    @(negedge clk);
    seq_done_valid = 1'b1;
    seq_done_idx = idx;
    @(negedge clk);
    seq_done_valid = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !busy) break;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && !busy, "R7", "frames left", 32'(exp_q.size()), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_off = 0;
    model_cnt = 0;
    rst_n = 1'b1;
  endtask

  // scoreboard monitor: samples 5 ns before each rising edge
  bit wchk = 1'b0;
  bit wexp = 1'b0;
  bit prev_stall = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (wchk) begin
          check(wrap_pulse == wexp, "R5", "wrap pulse", 32'(wrap_pulse), 32'(wexp));
          wchk = 1'b0;
        end
        if (prev_stall)
          check(dst_wr_valid && dst_wr_addr == prev_addr && dst_wr_data == prev_data,
                "R8", "held word", dst_wr_data, prev_data);
        prev_stall = dst_wr_valid && !dst_wr_ready;
        prev_addr = dst_wr_addr;
        prev_data = dst_wr_data;
        if (dst_wr_valid && dst_wr_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R1", "unexpected write addr", 32'(dst_wr_addr), 0);
          end else begin
            logic [AW+DW:0] e;
            e = exp_q.pop_front();
            check(dst_wr_addr == e[AW+DW-1:DW], "R4", "write address",
                  32'(dst_wr_addr), 32'(e[AW+DW-1:DW]));
            check(dst_wr_data == e[DW-1:0], "R3", "packed data",
                  dst_wr_data, e[DW-1:0]);
            wchk = 1'b1;
            wexp = e[AW+DW];
          end
        end
      end else begin
        prev_stall = 1'b0;
        wchk = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    // R9: reset state
    check(!dst_wr_valid && !src_rd_en && !busy && !wrap_pulse && !align_err,
          "R9", "reset outputs", {dst_wr_valid, src_rd_en, busy, wrap_pulse, align_err}, 0);

    // R1: other buffer indices do not trigger
    send_req(6'd2);
    send_req(6'd0);
    repeat (20) @(negedge clk);
    check(!busy && exp_q.size() == 0, "R1", "busy after non-matching index", 32'(busy), 0);

    // R2 R3 R4 R5: four frames on a three-word ring
    for (int f = 0; f < 4; f++) begin
      expect_frame();
      send_req(6'd3);
      drain();
    end

    // R2: odd source base, wider source stride, different destination stride
    do_reset();
    cfg_src_base = 16'h0041;
    cfg_src_stride = 8'd9;
    cfg_dst_stride = 8'd8;
    cfg_ring_words = 10'd4;
    for (int f = 0; f < 2; f++) begin
      expect_frame();
      send_req(6'd3);
      drain();
    end

    // R8: random back-pressure
    rand_ready = 1'b1;
    for (int f = 0; f < 6; f++) begin
      expect_frame();
      send_req(6'd3);
      drain();
    end

    // R7: requests during a frame merge into one pending frame
    rand_ready = 1'b0;
    @(negedge clk);
    dst_wr_ready = 1'b1;
    expect_frame();
    expect_frame();
    send_req(6'd3);
    send_req(6'd3);
    send_req(6'd3);
    drain();

    // R10: request in the same cycle as a wrapping write handshake
    do_reset();
    cfg_src_base = 16'h0010;
    cfg_src_stride = 8'd4;
    cfg_dst_stride = 8'd4;
    cfg_ring_words = 10'd1;
    @(negedge clk);
    dst_wr_ready = 1'b0;
    expect_frame();
    send_req(6'd3);
    for (int n = 0; n < 50; n++) begin
      if (dst_wr_valid) break;
      @(negedge clk);
    end
    check(dst_wr_valid, "R10", "word offered under stall", 32'(dst_wr_valid), 1);
    expect_frame();
    @(negedge clk);
    dst_wr_ready = 1'b1;
    seq_done_valid = 1'b1;
    seq_done_idx = 6'd3;
    @(negedge clk);
    seq_done_valid = 1'b0;
    drain();

    // R6: misaligned destination base
    cfg_dst_base = 16'h0102;
    send_req(6'd3);
    repeat (20) @(negedge clk);
    #5;
    check(align_err && !busy, "R6", "base misaligned flag", 32'(align_err), 1);
    send_req(6'd3);
    repeat (20) @(negedge clk);
    check(align_err, "R6", "flag sticky", 32'(align_err), 1);
    do_reset();
    @(negedge clk);
    check(!align_err, "R9", "flag cleared by reset", 32'(align_err), 0);
    // R6: misaligned destination stride
    cfg_dst_base = 16'h0100;
    cfg_dst_stride = 8'd6;
    send_req(6'd3);
    repeat (20) @(negedge clk);
    check(align_err && !busy, "R6", "stride misaligned flag", 32'(align_err), 1);
    check(exp_q.size() == 0, "R6", "no write issued", 32'(exp_q.size()), 0);

    finish_run();
  end

endmodule